// File: doc/BRIEF.md
# Interrupt Control and Status Word

This block holds one 32-bit interrupt word whose fields each follow their own access rule. Bit 0 is an enable that software sets and clears with ordinary writes. Bit 1 is a pending flag that hardware raises and software clears by writing 1. Bits 9:2 form an event counter that hardware increments and that a software read empties. Bit 10 shows the live state of an external line.

Each event pulse raises the pending flag and bumps the counter. The interrupt output is asserted while both the enable and the pending flag are set.

The register port works in a single cycle. `rd_data_o` always shows the current word. The read strobe marks a read that software consumes, and that read zeroes the counter at the clock edge that ends the access. Software can therefore look at the word without the strobe and leave it undisturbed, but any strobed read counts as a clearing read.

Top module: `irq_csr`

## Requirements
- R1: After reset, all fields read 0 and `irq_o` is 0.
- R2: Bit 0 (enable) takes the value of `wr_data_i[0]` on every write.
- R3: Bit 1 (pending) is set by an `event_i` pulse. A write with `wr_data_i[1]`=1 clears it, and a write with `wr_data_i[1]`=0 leaves it unchanged.
- R4: If an event arrives in the same cycle as a write that clears the pending flag, the flag stays set.
- R5: Bits 9:2 hold an 8-bit count that rises by 1 for each cycle in which `event_i` is high.
- R6: The count saturates at 255 and does not wrap.
- R7: A strobed read returns the current count in bits 9:2 and then zeroes the count, so a second back-to-back read returns 0.
- R8: If an event arrives in the same cycle as a strobed read, the read returns the old count and the count becomes 1 afterwards.
- R9: Bit 10 reflects `raw_i` directly and ignores writes.
- R10: Bits 31:11 always read 0. Writes to bits 31:11 and to bits 9:2 have no effect.
- R11: `irq_o` equals enable AND pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | 32 | Write data |
| rd_en_i | input | 1 | Read strobe that consumes the count |
| rd_data_o | output | 32 | Current register word |
| event_i | input | 1 | Event pulse, one event per high cycle |
| raw_i | input | 1 | Live line shown in bit 10 |
| irq_o | output | 1 | Interrupt request |

## Verification
A wrong pending or enable state shows on `irq_o` in the cycle after the edge that caused it. It also shows in bits 1:0 of the word without any strobed read. A wrong count stays hidden until the next look at bits 9:2, so the bench checks the word with a non-strobed look after every step. A strobed read that fails to clear only shows on the following read, so the bench always issues back-to-back reads and also reads at the collision cycles, where an event meets a clear.

// File: rtl/irq_csr_pkg.sv
package irq_csr_pkg;
  localparam int unsigned WORD_W  = 32;
  localparam int unsigned EN_BIT  = 0;
  localparam int unsigned PND_BIT = 1;
  localparam int unsigned CNT_LSB = 2;
endpackage

// File: rtl/irq_pend_flag.sv
module irq_pend_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= 1'b0;
    else if (set_i)  q_o <= 1'b1;  // hardware set wins over software clear
    else if (clr_i)  q_o <= 1'b0;
  end

  p_set_wins_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> q_o);
  p_w1c_clears_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> !q_o);
  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !set_i) |=> (q_o == $past(q_o)));
endmodule

// File: rtl/irq_evt_counter.sv
module irq_evt_counter #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic             rd_clr_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_o;
    if (rd_clr_i)                      cnt_d = inc_i ? CNT_ONE : '0;
    else if (inc_i && cnt_o != CNT_MAX) cnt_d = cnt_o + CNT_ONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_o <= '0;
    else         cnt_o <= cnt_d;
  end

  p_inc_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_clr_i && inc_i && cnt_o != CNT_MAX) |=> (cnt_o == $past(cnt_o) + CNT_ONE));
  p_no_overflow_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_clr_i && cnt_o == CNT_MAX) |=> (cnt_o == CNT_MAX));
  p_rd_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_clr_i && !inc_i) |=> (cnt_o == '0));
  p_rd_evt_keep_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_clr_i && inc_i) |=> (cnt_o == CNT_ONE));
endmodule

// File: rtl/irq_csr.sv
module irq_csr
  import irq_csr_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [WORD_W-1:0] wr_data_i,
  input  logic              rd_en_i,
  output logic [WORD_W-1:0] rd_data_o,
  input  logic              event_i,
  input  logic              raw_i,
  output logic              irq_o
);
  localparam int unsigned CNT_MSB = CNT_LSB + CNT_W - 1;
  localparam int unsigned RAW_BIT = CNT_MSB + 1;

  logic             en_q;
  logic             pend_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      en_q <= 1'b0;
    else if (wr_en_i) en_q <= wr_data_i[EN_BIT];
  end

  irq_pend_flag u_pend (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (event_i),
    .clr_i  (wr_en_i & wr_data_i[PND_BIT]),
    .q_o    (pend_q)
  );

  irq_evt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .inc_i    (event_i),
    .rd_clr_i (rd_en_i),
    .cnt_o    (cnt_q)
  );

  always_comb begin
    rd_data_o                   = '0;
    rd_data_o[EN_BIT]           = en_q;
    rd_data_o[PND_BIT]          = pend_q;
    rd_data_o[CNT_MSB:CNT_LSB]  = cnt_q;
    rd_data_o[RAW_BIT]          = raw_i;
  end

  assign irq_o = en_q & pend_q;

  p_enable_wr_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> (rd_data_o[EN_BIT] == $past(wr_data_i[EN_BIT])));
  p_enable_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(en_q));
  p_irq_needs_pend_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_data_i[PND_BIT] && !event_i) |=> !irq_o);
endmodule

// File: tb/tb_irq_csr.sv
module tb_irq_csr;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0, ev = 1'b0, raw = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        irq;
  int          n_run = 0, n_fail = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  irq_csr dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .rd_en_i(rd_en), .rd_data_o(rd_data), .event_i(ev), .raw_i(raw), .irq_o(irq)
  );

  function automatic logic [7:0] cnt_of(input logic [31:0] w);
    return w[9:2];
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  // Called at a negedge. Drives for one cycle and samples the word before the edge.
  task automatic cyc(input logic wr, input logic [31:0] wd, input logic rd, input logic e,
                     output logic [31:0] seen);
    wr_en = wr; wr_data = wd; rd_en = rd; ev = e;
    #1 seen = rd_data;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0; rd_en = 1'b0; ev = 1'b0;
  endtask

  task automatic peek(output logic [31:0] w);
    #1 w = rd_data;
  endtask

  task automatic wr(input logic [31:0] d);
    logic [31:0] s;
    cyc(1'b1, d, 1'b0, 1'b0, s);
  endtask

  task automatic rd(output logic [31:0] d);
    cyc(1'b0, '0, 1'b1, 1'b0, d);
  endtask

  task automatic pulse(input int n);
    logic [31:0] s;
    for (int i = 0; i < n; i++) cyc(1'b0, '0, 1'b0, 1'b1, s);
  endtask

  task automatic t_reset;
    logic [31:0] w;
    peek(w);
    check("R1 word", w, 32'h0);
    check("R1 irq", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_enable;
    logic [31:0] w;
    wr(32'h1); peek(w);
    check("R2 set", w, 32'h1);
    check("R11 no pend", {31'b0, irq}, 32'h0);
    wr(32'h0); peek(w);
    check("R2 clr", w, 32'h0);
  endtask

  task automatic t_pending;
    logic [31:0] w, s;
    rd(s);
    pulse(1); peek(w);
    check("R3 set", {31'b0, w[1]}, 32'h1);
    check("R11 en off", {31'b0, irq}, 32'h0);
    wr(32'h1); peek(w);
    check("R3 w0 hold", {31'b0, w[1]}, 32'h1);
    check("R11 irq on", {31'b0, irq}, 32'h1);
    wr(32'h3); peek(w);
    check("R3 w1c", w[1:0], 32'h1);
    check("R11 irq off", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_w1c_race;
    logic [31:0] w, s;
    cyc(1'b1, 32'h3, 1'b0, 1'b1, s); peek(w);
    check("R4 set wins", {31'b0, w[1]}, 32'h1);
    check("R4 irq", {31'b0, irq}, 32'h1);
    wr(32'h2); peek(w);
    check("R4 later clear", w[1:0], 32'h0);
  endtask

  task automatic t_count;
    logic [31:0] w, s;
    rd(s);
    peek(w); check("R7 cleared", {24'b0, cnt_of(w)}, 32'h0);
    pulse(5); peek(w);
    check("R5 count", {24'b0, cnt_of(w)}, 32'd5);
    peek(w); check("R7 look no clear", {24'b0, cnt_of(w)}, 32'd5);
    wr(32'h0000_03FC); peek(w);
    check("R10 cnt wr ignored", {24'b0, cnt_of(w)}, 32'd5);
    rd(s); check("R7 first read", {24'b0, cnt_of(s)}, 32'd5);
    rd(s); check("R7 second read", {24'b0, cnt_of(s)}, 32'd0);
  endtask

  task automatic t_sat;
    logic [31:0] w, s;
    rd(s);
    pulse(300); peek(w);
    check("R6 saturate", {24'b0, cnt_of(w)}, 32'd255);
    rd(s); check("R6 read max", {24'b0, cnt_of(s)}, 32'd255);
    peek(w); check("R7 clr after max", {24'b0, cnt_of(w)}, 32'd0);
  endtask

  task automatic t_rd_event;
    logic [31:0] w, s;
    pulse(3);
    cyc(1'b0, '0, 1'b1, 1'b1, s);
    check("R8 old value", {24'b0, cnt_of(s)}, 32'd3);
    peek(w); check("R8 keeps event", {24'b0, cnt_of(w)}, 32'd1);
    rd(s);
  endtask

  task automatic t_raw_upper;
    logic [31:0] w;
    wr(32'h0000_0003);
    raw = 1'b1; peek(w);
    check("R9 raw high", {31'b0, w[10]}, 32'h1);
    wr(32'hFFFF_FC00); peek(w);
    check("R10 upper zero", w & 32'hFFFF_F800, 32'h0);
    check("R9 raw kept", {31'b0, w[10]}, 32'h1);
    raw = 1'b0; peek(w);
    check("R9 raw low", {31'b0, w[10]}, 32'h0);
    check("R10 word", w, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_enable();
    t_pending();
    t_w1c_race();
    t_count();
    t_sat();
    t_rd_event();
    t_raw_upper();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule